// File: doc/BRIEF.md
# Bit-Serial SAD Array with Early Termination

This block measures how well one candidate 4x4 reference patch matches a 4x4 current block. It returns the sum of absolute differences (SAD) of the sixteen pixel pairs. Sixteen processing elements sit in a 4x4 grid, one per pixel pair. Each element forms its 8-bit absolute difference in a single step. After that it offers one magnitude bit per clock, starting with the most significant bit. A popcount of the sixteen bits in the current bit-plane is weighted by that plane's power of two and added to a running sum.

Because the high planes are added first, the running sum never decreases and is always a lower bound on the final SAD. The caller supplies the best SAD found so far as a threshold with every candidate. When the running sum reaches that threshold before the last plane, the candidate cannot win, so the array stops and reports it as terminated early. Reference pixels are held in the elements and can move one column left per candidate. A new right-hand column is fed in from outside, so stepping across a search row reloads only four pixels.

A search controller drives one candidate per start pulse and waits for the done strobe. It then feeds the result back as the next threshold if it is a new best.

Top module: `msb_sad_array`

## Requirements
- R1: While rst_ni is low and after its release, done_o and early_o are 0 and sad_o is 0.
- R2: A candidate that is not terminated returns the exact 4x4 SAD on sad_o with early_o = 0. done_o is high in the cycle after the 9th rising edge that follows the edge sampling start_i.
- R3: Pixel (row r, column c), r and c in 0..3, occupies bits [(4*r+c)*8 +: 8] of cur_pix_i and ref_pix_i. Row r of the incoming column occupies bits [r*8 +: 8] of ref_col_i.
- R4: Bit-planes are consumed from bit 7 down to bit 0. After plane k, the running sum equals the SAD computed with bits below k of every absolute difference cleared.
- R5: If the running sum after plane k, with k from 7 down to 1, is greater than or equal to the threshold, the evaluation stops. done_o then rises 9-k edges after the start edge, early_o = 1, and sad_o holds that running sum.
- R6: A threshold reached only at plane 0 is not early: early_o = 0 and sad_o is the full SAD.
- R7: A threshold of 0xFFFF never terminates a candidate.
- R8: With ref_mode_i = 1 at start, every stored reference pixel takes the value of its right neighbour. Column 3 of row r takes row r of ref_col_i, and the current pixels are reloaded from cur_pix_i. With ref_mode_i = 0, all reference pixels load from ref_pix_i.
- R9: A start_i pulse during an evaluation is ignored: the running result and all stored pixels and threshold stay untouched.
- R10: done_o is a one-cycle pulse. sad_o and early_o change only together with done_o and hold until the next one.
- R11: A candidate flagged early always has a true SAD not below its threshold, so a best-so-far search never drops the true minimum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a candidate (sampled when idle) |
| ref_mode_i | input | 1 | 0: full reference load, 1: shift left by one column |
| cur_pix_i | input | 128 | Sixteen current pixels, 8 bits each |
| ref_pix_i | input | 128 | Sixteen reference pixels for a full load |
| ref_col_i | input | 32 | New right-hand reference column, one pixel per row |
| thresh_i | input | 16 | Best SAD so far; termination threshold |
| sad_o | output | 12 | Candidate SAD, or running sum at termination |
| done_o | output | 1 | One-cycle pulse per finished candidate |
| early_o | output | 1 | Candidate was terminated before plane 0 |

## Verification
The hardest situation to reach is termination at a chosen intermediate plane. It requires a running sum that crosses the threshold exactly at that plane. The stimulus uses uniform blocks whose plane sums are known in closed form and sets the threshold to the running sum of the target plane. Random blocks are also run with thresholds set equal to and one above their computed running sums. A search row of column shifts with the threshold fed back from the best result shows that a terminated candidate is never the true minimum. A second start pulse injected mid-evaluation, followed by a shift, shows that neither the result nor the stored reference was disturbed.

// File: rtl/sad_pkg.sv
package sad_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DIFF  = 2'd1,
    ST_PLANE = 2'd2
  } sad_state_e;

  function automatic logic [7:0] abs_diff8(input logic [7:0] a, input logic [7:0] b);
    return (a > b) ? (a - b) : (b - a);
  endfunction

endpackage

// File: rtl/sad_pe.sv
module sad_pe #(
  parameter int PIX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_i,
  input  logic             shift_mode_i,
  input  logic [PIX_W-1:0] cur_i,
  input  logic [PIX_W-1:0] ref_bus_i,
  input  logic [PIX_W-1:0] ref_nbr_i,
  input  logic             diff_ld_i,
  input  logic             plane_adv_i,
  output logic [PIX_W-1:0] ref_o,
  output logic             bit_o
);

  logic [PIX_W-1:0] cur_q, ref_q, mag_q, mag_d;

  always_comb begin
    mag_d = (cur_q > ref_q) ? (cur_q - ref_q) : (ref_q - cur_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= '0;
      ref_q <= '0;
    end else if (ld_i) begin
      cur_q <= cur_i;
      ref_q <= shift_mode_i ? ref_nbr_i : ref_bus_i;
    end
  end

  // magnitude shifts left so the current plane is always at the top bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          mag_q <= '0;
    else if (diff_ld_i)   mag_q <= mag_d;
    else if (plane_adv_i) mag_q <= {mag_q[PIX_W-2:0], 1'b0};
  end

  assign ref_o = ref_q;
  assign bit_o = mag_q[PIX_W-1];

  // R4: the magnitude captured at the load step is the unsigned distance
  assert_mag_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(diff_ld_i) |-> (mag_q == (($past(cur_q) > $past(ref_q)) ?
                                    ($past(cur_q) - $past(ref_q)) :
                                    ($past(ref_q) - $past(cur_q)))));

endmodule

// File: rtl/sad_plane_count.sv
module sad_plane_count #(
  parameter int N = 16,
  localparam int CNT_W = $clog2(N + 1)
) (
  input  logic [N-1:0]     bits_i,
  output logic [CNT_W-1:0] cnt_o
);

  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < N; i++) cnt_o = cnt_o + CNT_W'(bits_i[i]);
  end

endmodule

// File: rtl/sad_ctrl.sv
module sad_ctrl
  import sad_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int N     = 16,
  parameter int THR_W = 16,
  parameter int SAD_W = 12,
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [THR_W-1:0] thresh_i,
  input  logic [CNT_W-1:0] plane_cnt_i,
  output logic             accept_o,
  output logic             diff_ld_o,
  output logic             plane_adv_o,
  output logic [SAD_W-1:0] sad_o,
  output logic             done_o,
  output logic             early_o
);

  localparam int KW    = $clog2(PIX_W);
  localparam int CMP_W = (SAD_W > THR_W) ? SAD_W : THR_W;
  localparam int MAX_SAD = N * ((1 << PIX_W) - 1);

  sad_state_e       state_q;
  logic [KW-1:0]    k_q;
  logic [SAD_W-1:0] acc_q, acc_nxt;
  logic [THR_W-1:0] thr_q;
  logic             stop_early;

  assign accept_o    = start_i && (state_q == ST_IDLE);
  assign diff_ld_o   = (state_q == ST_DIFF);
  assign plane_adv_o = (state_q == ST_PLANE);

  always_comb begin
    acc_nxt    = acc_q + (SAD_W'(plane_cnt_i) << k_q);
    stop_early = (k_q != '0) && (CMP_W'(acc_nxt) >= CMP_W'(thr_q));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      k_q     <= '0;
      acc_q   <= '0;
      thr_q   <= '0;
      sad_o   <= '0;
      done_o  <= 1'b0;
      early_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept_o) begin
          thr_q   <= thresh_i;
          acc_q   <= '0;
          state_q <= ST_DIFF;
        end
        ST_DIFF: begin
          k_q     <= KW'(PIX_W - 1);
          state_q <= ST_PLANE;
        end
        ST_PLANE: begin
          acc_q <= acc_nxt;
          if (k_q == '0 || stop_early) begin
            state_q <= ST_IDLE;
            done_o  <= 1'b1;
            sad_o   <= acc_nxt;
            early_o <= stop_early;
          end else begin
            k_q <= k_q - 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_result_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(sad_o) && $stable(early_o)));

  assert_no_early_done_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(accept_o) |-> !done_o);

  assert_sad_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(sad_o) <= MAX_SAD);

  assert_acc_monotone_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PLANE && $past(state_q == ST_PLANE)) |-> (acc_q >= $past(acc_q)));

  assert_early_above_thr_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && early_o) |-> (CMP_W'(sad_o) >= CMP_W'(thr_q)));

  assert_thr_frozen_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |=> $stable(thr_q));

endmodule

// File: rtl/msb_sad_array.sv
module msb_sad_array #(
  parameter int PIX_W = 8,
  parameter int ROWS  = 4,
  parameter int COLS  = 4,
  parameter int THR_W = 16,
  localparam int N       = ROWS * COLS,
  localparam int MAX_SAD = N * ((1 << PIX_W) - 1),
  localparam int SAD_W   = $clog2(MAX_SAD + 1),
  localparam int CNT_W   = $clog2(N + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                ref_mode_i,
  input  logic [N*PIX_W-1:0]  cur_pix_i,
  input  logic [N*PIX_W-1:0]  ref_pix_i,
  input  logic [ROWS*PIX_W-1:0] ref_col_i,
  input  logic [THR_W-1:0]    thresh_i,
  output logic [SAD_W-1:0]    sad_o,
  output logic                done_o,
  output logic                early_o
);

  logic             accept, diff_ld, plane_adv;
  logic [N-1:0]     plane_bits;
  logic [CNT_W-1:0] plane_cnt;
  logic [PIX_W-1:0] ref_w [N];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int P = r * COLS + c;
      logic [PIX_W-1:0] nbr;
      if (c == COLS - 1) begin : g_edge
        assign nbr = ref_col_i[r*PIX_W +: PIX_W];
      end else begin : g_inner
        assign nbr = ref_w[P+1];
      end
      sad_pe #(.PIX_W(PIX_W)) u_pe (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .ld_i        (accept),
        .shift_mode_i(ref_mode_i),
        .cur_i       (cur_pix_i[P*PIX_W +: PIX_W]),
        .ref_bus_i   (ref_pix_i[P*PIX_W +: PIX_W]),
        .ref_nbr_i   (nbr),
        .diff_ld_i   (diff_ld),
        .plane_adv_i (plane_adv),
        .ref_o       (ref_w[P]),
        .bit_o       (plane_bits[P])
      );
    end
    // R8: the left-hand element takes over its neighbour's pixel on a shift
    assert_row_shift_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(accept && ref_mode_i) |-> (ref_w[r*COLS] == $past(ref_w[r*COLS+1])));
  end

  sad_plane_count #(.N(N)) u_cnt (
    .bits_i(plane_bits),
    .cnt_o (plane_cnt)
  );

  sad_ctrl #(
    .PIX_W(PIX_W), .N(N), .THR_W(THR_W), .SAD_W(SAD_W), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .thresh_i   (thresh_i),
    .plane_cnt_i(plane_cnt),
    .accept_o   (accept),
    .diff_ld_o  (diff_ld),
    .plane_adv_o(plane_adv),
    .sad_o      (sad_o),
    .done_o     (done_o),
    .early_o    (early_o)
  );

endmodule

// File: tb/sim_msb_sad_array.sv
module sim_msb_sad_array;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic         ref_mode_i = 1'b0;
  logic [127:0] cur_pix_i = '0;
  logic [127:0] ref_pix_i = '0;
  logic [31:0]  ref_col_i = '0;
  logic [15:0]  thresh_i = '0;
  logic [11:0]  sad_o;
  logic         done_o, early_o;

  int total = 0, bad = 0;
  bit finished = 0;
  int cur_m [16];
  int ref_m [16];
  int col_m [4];
  int last_sad, last_early, last_lat, best;

  always #5 clk = ~clk;

  msb_sad_array u0 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .ref_mode_i(ref_mode_i),
    .cur_pix_i(cur_pix_i), .ref_pix_i(ref_pix_i), .ref_col_i(ref_col_i),
    .thresh_i(thresh_i), .sad_o(sad_o), .done_o(done_o), .early_o(early_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int true_sad();
    int s = 0;
    for (int p = 0; p < 16; p++) s += (cur_m[p] > ref_m[p]) ? cur_m[p] - ref_m[p] : ref_m[p] - cur_m[p];
    return s;
  endfunction

  // expected result from the requirements: MSB-first partial sums, stop at k>0
  task automatic model(input int thr, output int sad, output int early, output int lat);
    int part = 0;
    early = 0; lat = 9; sad = 0;
    for (int k = 7; k >= 0; k--) begin
      for (int p = 0; p < 16; p++) begin
        int d = (cur_m[p] > ref_m[p]) ? cur_m[p] - ref_m[p] : ref_m[p] - cur_m[p];
        part += ((d >> k) & 1) << k;
      end
      if (k > 0 && part >= thr) begin
        early = 1; lat = 9 - k; sad = part;
        return;
      end
    end
    sad = part;
  endtask

  task automatic pack(input bit mode, input int thr);
    for (int p = 0; p < 16; p++) begin
      cur_pix_i[p*8 +: 8] = 8'(cur_m[p]);
      ref_pix_i[p*8 +: 8] = mode ? 8'hA5 : 8'(ref_m[p]);
    end
    for (int r = 0; r < 4; r++) ref_col_i[r*8 +: 8] = 8'(col_m[r]);
    ref_mode_i = mode;
    thresh_i = 16'(thr);
  endtask

  task automatic shift_model();
    for (int r = 0; r < 4; r++) begin
      for (int c = 0; c < 3; c++) ref_m[r*4+c] = ref_m[r*4+c+1];
      ref_m[r*4+3] = col_m[r];
    end
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (n < 40) begin
      @(negedge clk);
      n++;
      if (done_o) break;
    end
    if (!done_o) begin
      chk(0, "watchdog", n, 9);
      n = -1;
    end
  endtask

  // drive one candidate from the model and check every observable result
  task automatic run_cand(input bit mode, input int thr, input string req);
    int es, ee, el, n, s_hold;
    if (mode) shift_model();
    model(thr, es, ee, el);
    @(negedge clk);
    pack(mode, thr);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_done(n);
    chk(n == el, {req, " latency"}, n, el);
    chk(int'(sad_o) == es, {req, " sad"}, int'(sad_o), es);
    chk(int'(early_o) == ee, {req, " early"}, int'(early_o), ee);
    if (early_o) chk(true_sad() >= thr, "R11 early candidate below threshold", true_sad(), thr);
    last_sad = int'(sad_o); last_early = int'(early_o); last_lat = n;
    s_hold = int'(sad_o);
    @(negedge clk);
    chk(done_o == 1'b0, "R10 done pulse width", int'(done_o), 0);
    chk(int'(sad_o) == s_hold, "R10 sad held", int'(sad_o), s_hold);
  endtask

  task automatic fill_uniform(input int cv, input int rv);
    for (int p = 0; p < 16; p++) begin cur_m[p] = cv; ref_m[p] = rv; end
  endtask

  task automatic fill_random();
    for (int p = 0; p < 16; p++) begin cur_m[p] = int'($urandom_range(0, 255)); ref_m[p] = int'($urandom_range(0, 255)); end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(done_o == 0 && early_o == 0 && sad_o == 0, "R1 in reset", int'(sad_o), 0);
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(done_o == 0 && early_o == 0 && sad_o == 0, "R1 after reset", int'(sad_o), 0);
  endtask

  task automatic t_full();
    fill_uniform(0, 0);       run_cand(0, 16'hFFFF, "R2 zero block");
    fill_uniform(255, 0);     run_cand(0, 16'hFFFF, "R2 max block");
    for (int i = 0; i < 6; i++) begin
      fill_random();          run_cand(0, 16'hFFFF, "R3 R7 random full");
      chk(last_sad == true_sad(), "R2 exact sad", last_sad, true_sad());
    end
  endtask

  task automatic t_early();
    // all differences 255: running sums 2048,3072,...,4064,4080
    fill_uniform(255, 0);
    run_cand(0, 2048, "R5 stop at plane 7");
    chk(last_lat == 2, "R4 plane 7 first", last_lat, 2);
    run_cand(0, 2049, "R5 stop at plane 6");
    run_cand(0, 4064, "R5 stop at plane 1");
    run_cand(0, 4080, "R6 threshold at plane 0");
    chk(last_early == 0 && last_sad == 4080, "R6 not early", last_sad, 4080);
    // difference 0x50 everywhere: plane 6 adds 1024, plane 4 adds 256
    fill_uniform(16'h50, 0);
    run_cand(0, 1025, "R4 skip empty plane 5");
    chk(last_sad == 1280 && last_lat == 5, "R4 partial at plane 4", last_sad, 1280);
    for (int i = 0; i < 6; i++) begin
      int s = 0, e, l;
      fill_random();
      model(16'hFFFF, s, e, l);
      run_cand(0, s, "R5 R6 random thr=sad");
      run_cand(0, s + 1, "R7 random thr above");
      chk(last_sad == s && last_early == 0, "R7 full when above", last_sad, s);
      run_cand(0, s / 2, "R5 random thr half");
    end
  endtask

  task automatic t_layout();
    fill_uniform(0, 0);
    ref_m[1*4+2] = 200;
    col_m = '{0, 0, 0, 0};
    run_cand(0, 16'hFFFF, "R3 load single pixel");
    run_cand(1, 16'hFFFF, "R8 shift to col1");
    run_cand(1, 16'hFFFF, "R8 shift to col0");
    run_cand(1, 16'hFFFF, "R8 shifted out");
    chk(last_sad == 0, "R8 pixel left the array", last_sad, 0);
    col_m = '{0, 0, 77, 0};
    run_cand(1, 16'hFFFF, "R3 R8 column row 2 enters");
    chk(last_sad == 77, "R3 ref_col row order", last_sad, 77);
  endtask

  task automatic t_search();
    int mn;
    fill_random();
    run_cand(0, 16'hFFFF, "R11 search first");
    best = last_sad; mn = true_sad();
    for (int i = 0; i < 12; i++) begin
      for (int r = 0; r < 4; r++) col_m[r] = int'($urandom_range(0, 255));
      run_cand(1, best, "R8 R11 search step");
      if (true_sad() < mn) mn = true_sad();
      if (!last_early && last_sad < best) best = last_sad;
    end
    chk(best == mn, "R11 best equals true minimum", best, mn);
  endtask

  task automatic t_ignore();
    int es, ee, el, n;
    int ref_save [16];
    fill_random();
    model(16'hFFFF, es, ee, el);
    ref_save = ref_m;
    @(negedge clk);
    pack(0, 16'hFFFF);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (3) @(negedge clk);
    cur_pix_i = {16{8'h33}};
    ref_pix_i = {16{8'hCC}};
    thresh_i = 16'd0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_done(n);
    chk(n == 5, "R9 latency unaffected", n + 4, 9);
    chk(int'(sad_o) == es && early_o == 0, "R9 result unaffected", int'(sad_o), es);
    ref_m = ref_save;
    for (int r = 0; r < 4; r++) col_m[r] = int'($urandom_range(0, 255));
    run_cand(1, 16'hFFFF, "R9 stored ref unaffected");
  endtask

  initial begin
    t_reset();
    t_full();
    t_early();
    t_layout();
    t_search();
    t_ignore();
    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule